// File: doc/BRIEF.md
# Peripheral Clock Gating Controller

This block starts and stops the clock of each on-chip peripheral to save power. Software programs it through a small byte-wide register bus that has an address, a write strobe, write data and registered read data. Two enable registers hold one bit per peripheral, and a third register chooses clock sources for two asynchronous CAN channels and for a sound generator.

Each enable bit controls three things at the same time. It gates the peripheral's clock through a glitch-free latch-based gate. It holds the peripheral in reset while the bit is clear. It also drives a write-permit output, which the peripheral register-bus filter uses to drop writes while still allowing reads.

The reset release is synchronous and is delayed until the gated clock has been running for two source-clock cycles. The reset is reasserted as soon as the enable bit is cleared. Eleven peripherals are covered. The LCD peripheral manages its own clocking and has no bit here.

Top module: `pcg_top`

## Requirements
- R1: While `rst` is high at a rising edge, all three registers become 0x00. From then on every `periph_gclk` bit stays low, every `periph_rst` bit is high, every `periph_wr_ok` bit is low, and `can_clk_en`, `can_clk_sel` and `sg_clk_sel` are 0.
- R2: Enable register A is at address 0. Its bits 0 to 7 control peripherals 0 to 7: timer units 0, 1 and 2, serial units 0 and 1, LIN channels 0 and 1, and the real-time clock, in that order. All eight bits are writable.
- R3: Enable register B is at address 1. Bit 4 controls peripheral 8 (sound generator), bit 5 controls peripheral 9 (motor controller) and bit 7 controls peripheral 10 (A/D converter). Bits 0, 1, 2, 3 and 6 read as 0 and ignore writes.
- R4: The clock-select register is at address 2. It maps bit 6 to `can_clk_en[1]`, bit 5 to `can_clk_sel[1]`, bit 4 to `can_clk_en[0]`, bit 3 to `can_clk_sel[0]` and bit 0 to `sg_clk_sel`. Bits 7, 2 and 1 read as 0 and ignore writes.
- R5: While a peripheral's enable bit is 0, its `periph_wr_ok` is low, its `periph_rst` is high, and its `periph_gclk` stays low from the first rising edge after the clearing write onward.
- R6: When a write sets an enable bit, `periph_wr_ok` is high right after that write edge. `periph_gclk` then follows `clk` starting from the next rising edge.
- R7: `periph_gclk` is never high while `clk` is low, so no runt pulse occurs when enables toggle.
- R8: After the edge that sets an enable bit, `periph_rst` stays high for three more rising edges and falls after the third. This is two cycles after the gated clock starts. A write that clears the bit raises `periph_rst` right after its write edge.
- R9: A write to address 3 (unmapped) changes no register, and a read of address 3 returns 0x00.
- R10: `bus_rdata` is registered. After a rising edge it shows the register selected by `bus_addr` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for registers and gates |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| periph_gclk | output | 11 | Gated clock per peripheral |
| periph_rst | output | 11 | Active-high reset per peripheral |
| periph_wr_ok | output | 11 | Write permit per peripheral |
| can_clk_en | output | 2 | CAN channel clock enable |
| can_clk_sel | output | 2 | CAN channel clock source select |
| sg_clk_sel | output | 1 | Sound generator clock source select |

## Verification
The enable registers are driven in three ways:
- Walking-one and walking-zero patterns show that each bit reaches its own peripheral index and no other.
- A sequence of varied byte values written back to back shows that the gated clocks follow the latched enables edge by edge, and that the clocks stay low in every low phase.
- All-ones writes to enable register B and to the clock-select register show that the reserved bits stay at zero.

A single enable is traced cycle by cycle through its set and its clear, which separates the immediate write-permit from the delayed reset release. Writes and reads at the unmapped address, followed by readback of the real registers, separate a decoding fault from a harmless access.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
package pcg_pkg;
  localparam int REG_W      = 8;
  localparam int REG_ADDR_W = 2;
  localparam int NUM_EN_A   = 8;
  localparam int NUM_PERIPH = NUM_EN_A + 3;
  localparam int NUM_CAN    = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_EN_A = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_EN_B = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CSEL = 2'd2;

  // writable bits of each register
  localparam logic [REG_W-1:0] MASK_EN_A = 8'hFF;
  localparam logic [REG_W-1:0] MASK_EN_B = 8'hB0;
  localparam logic [REG_W-1:0] MASK_CSEL = 8'h79;

  // field positions inside enable register B
  localparam int EN_B_SG_BIT  = 4;
  localparam int EN_B_MTR_BIT = 5;
  localparam int EN_B_ADC_BIT = 7;

  // clock-select fields: channel c uses select at CAN_BASE+2c, enable above it
  localparam int CAN_BASE   = 3;
  localparam int SG_SEL_BIT = 0;

  // reset release delay in source-clock cycles after the gated clock starts
  localparam int RST_DELAY = 2;
endpackage

// File: rtl/pcg_regfile.sv
`timescale 1ns/1ps
module pcg_regfile
  import pcg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic                  we,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic [NUM_PERIPH-1:0] periph_en,
  output logic [NUM_CAN-1:0]    can_en,
  output logic [NUM_CAN-1:0]    can_sel,
  output logic                  sg_sel
);
  logic [REG_W-1:0] en_a_q, en_b_q, csel_q;
  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_a_q <= '0;
      en_b_q <= '0;
      csel_q <= '0;
    end else if (we) begin
      unique case (addr)
        ADDR_EN_A: en_a_q <= wdata & MASK_EN_A;
        ADDR_EN_B: en_b_q <= wdata & MASK_EN_B;
        ADDR_CSEL: csel_q <= wdata & MASK_CSEL;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_EN_A: rd_mux = en_a_q;
      ADDR_EN_B: rd_mux = en_b_q;
      ADDR_CSEL: rd_mux = csel_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assign periph_en = {en_b_q[EN_B_ADC_BIT], en_b_q[EN_B_MTR_BIT],
                      en_b_q[EN_B_SG_BIT], en_a_q[NUM_EN_A-1:0]};
  assign sg_sel    = csel_q[SG_SEL_BIT];

  for (genvar c = 0; c < NUM_CAN; c++) begin : g_can
    assign can_sel[c] = csel_q[CAN_BASE + 2*c];
    assign can_en[c]  = csel_q[CAN_BASE + 2*c + 1];
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (en_a_q == '0 && en_b_q == '0 && csel_q == '0));
  // R3
  en_b_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_EN_B) |-> ((rdata & ~MASK_EN_B) == '0));
  // R4
  csel_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_CSEL) |-> ((rdata & ~MASK_CSEL) == '0));
  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == 2'd3) |=> ($stable(en_a_q) && $stable(en_b_q) && $stable(csel_q)));
  // R9
  unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == 2'd3) |-> (rdata == '0));
endmodule

// File: rtl/pcg_clk_gate.sv
`timescale 1ns/1ps
module pcg_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  // transparent only in the low phase, so the enable cannot change mid-pulse
  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/pcg_rst_sync.sv
`timescale 1ns/1ps
module pcg_rst_sync #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic prst
);
  localparam int DEPTH = DELAY + 1;
  logic [DEPTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !en) sh_q <= '0;
    else            sh_q <= {sh_q[DEPTH-2:0], 1'b1};
  end

  // assert at once on a clear, release after the shift chain fills
  assign prst = !(en && sh_q[DEPTH-1]);

  // R8
  rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> prst);
  if (DELAY >= 2) begin : g_rel_chk
    // R8
    rst_release_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(prst) |-> ($past(en) && $past(en, 2)));
  end
endmodule

// File: rtl/pcg_top.sv
`timescale 1ns/1ps
module pcg_top
  import pcg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic                  bus_we,
  input  logic [REG_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]      bus_rdata,
  output logic [NUM_PERIPH-1:0] periph_gclk,
  output logic [NUM_PERIPH-1:0] periph_rst,
  output logic [NUM_PERIPH-1:0] periph_wr_ok,
  output logic [NUM_CAN-1:0]    can_clk_en,
  output logic [NUM_CAN-1:0]    can_clk_sel,
  output logic                  sg_clk_sel
);
  logic [NUM_PERIPH-1:0] en;

  pcg_regfile u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (bus_addr),
    .we        (bus_we),
    .wdata     (bus_wdata),
    .rdata     (bus_rdata),
    .periph_en (en),
    .can_en    (can_clk_en),
    .can_sel   (can_clk_sel),
    .sg_sel    (sg_clk_sel)
  );

  assign periph_wr_ok = en;

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
    pcg_clk_gate u_gate (
      .clk  (clk),
      .en   (en[p]),
      .gclk (periph_gclk[p])
    );
    pcg_rst_sync #(.DELAY(RST_DELAY)) u_rst (
      .clk  (clk),
      .rst  (rst),
      .en   (en[p]),
      .prst (periph_rst[p])
    );
    // R5
    wr_block_rst_chk: assert property (@(posedge clk) disable iff (rst)
      !periph_wr_ok[p] |-> periph_rst[p]);
  end
endmodule

// File: tb/pcg_top_tb.sv
`timescale 1ns/1ps
module pcg_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [10:0] periph_gclk, periph_rst, periph_wr_ok;
  logic [1:0]  can_clk_en, can_clk_sel;
  logic        sg_clk_sel;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcg_top u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  function automatic logic [10:0] en_vec(input logic [7:0] a, input logic [7:0] b);
    return {b[7], b[5], b[4], a};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(periph_rst == 11'h7FF, "R1 rst", periph_rst, 11'h7FF);
    chk(periph_wr_ok == '0, "R1 wr_ok", periph_wr_ok, 0);
    chk({can_clk_en, can_clk_sel, sg_clk_sel} == '0, "R1 sel", {can_clk_en, can_clk_sel, sg_clk_sel}, 0);
    @(posedge clk); #1;
    chk(periph_gclk == '0, "R1 gclk", periph_gclk, 0);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      chk(d == 8'h00, "R1 reg", d, 0);
    end
  endtask

  task automatic t_walk_a();
    logic [7:0] d;
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 8'h01 << i);
      chk(periph_wr_ok == en_vec(8'h01 << i, 8'h00), "R2 walk1", periph_wr_ok, en_vec(8'h01 << i, 8'h00));
      rd(2'd0, d);
      chk(d == (8'h01 << i), "R10 readback", d, 8'h01 << i);
      wr(2'd0, ~(8'h01 << i));
      chk(periph_wr_ok == en_vec(~(8'h01 << i), 8'h00), "R2 walk0", periph_wr_ok, en_vec(~(8'h01 << i), 8'h00));
    end
    wr(2'd0, 8'h00);
  endtask

  task automatic t_reg_b();
    logic [7:0] d;
    wr(2'd1, 8'hFF);
    chk(periph_wr_ok == 11'h700, "R3 map", periph_wr_ok, 11'h700);
    rd(2'd1, d);
    chk(d == 8'hB0, "R3 rsvd", d, 8'hB0);
    wr(2'd1, 8'h4F);
    chk(periph_wr_ok == 11'h000, "R3 ignore", periph_wr_ok, 0);
    rd(2'd1, d);
    chk(d == 8'h00, "R3 rsvd0", d, 0);
    wr(2'd1, 8'h20);
    chk(periph_wr_ok == 11'h200, "R3 motor", periph_wr_ok, 11'h200);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_csel();
    logic [7:0] d;
    wr(2'd2, 8'hFF);
    rd(2'd2, d);
    chk(d == 8'h79, "R4 rsvd", d, 8'h79);
    chk({can_clk_en, can_clk_sel, sg_clk_sel} == 5'b11111, "R4 all", {can_clk_en, can_clk_sel, sg_clk_sel}, 5'h1F);
    wr(2'd2, 8'h41);
    chk(can_clk_en == 2'b10 && can_clk_sel == 2'b00 && sg_clk_sel, "R4 en1 sg", {can_clk_en, can_clk_sel, sg_clk_sel}, 5'b10001);
    wr(2'd2, 8'h08);
    chk(can_clk_en == 2'b00 && can_clk_sel == 2'b01 && !sg_clk_sel, "R4 sel0", {can_clk_en, can_clk_sel, sg_clk_sel}, 5'b00010);
    wr(2'd2, 8'h30);
    chk(can_clk_en == 2'b01 && can_clk_sel == 2'b10, "R4 ch mix", {can_clk_en, can_clk_sel}, 4'b0110);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_timing();
    wr(2'd0, 8'h01);
    chk(periph_wr_ok[0] && !periph_gclk[0], "R6 wr_ok now", {periph_wr_ok[0], periph_gclk[0]}, 2'b10);
    chk(periph_rst[0], "R8 hold0", periph_rst[0], 1);
    @(posedge clk); #1;
    chk(periph_gclk[0], "R6 gclk start", periph_gclk[0], 1);
    @(negedge clk);
    chk(periph_rst[0], "R8 hold1", periph_rst[0], 1);
    @(negedge clk);
    chk(periph_rst[0], "R8 hold2", periph_rst[0], 1);
    @(negedge clk);
    chk(!periph_rst[0], "R8 release", periph_rst[0], 0);
    wr(2'd0, 8'h00);
    chk(periph_rst[0] && !periph_wr_ok[0], "R5 clear", {periph_rst[0], periph_wr_ok[0]}, 2'b10);
    @(posedge clk); #1;
    chk(!periph_gclk[0], "R5 gclk stop", periph_gclk[0], 0);
    repeat (4) @(negedge clk);
    chk(periph_rst[0], "R5 rst held", periph_rst[0], 1);
  endtask

  task automatic t_gate_seq();
    logic [7:0] v;
    for (int i = 0; i < 16; i++) begin
      v = 8'(i * 37 + 5);
      wr(2'd0, v);
      #1;
      chk(periph_gclk == '0, "R7 low phase", periph_gclk, 0);
      @(posedge clk); #1;
      chk(periph_gclk == en_vec(v, 8'h00), "R6 gclk follow", periph_gclk, en_vec(v, 8'h00));
    end
    wr(2'd0, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h90);
    wr(2'd2, 8'h28);
    wr(2'd3, 8'hFF);
    rd(2'd3, d);
    chk(d == 8'h00, "R9 read", d, 0);
    rd(2'd0, d);
    chk(d == 8'hA5, "R9 en_a kept", d, 8'hA5);
    rd(2'd1, d);
    chk(d == 8'h90, "R9 en_b kept", d, 8'h90);
    rd(2'd2, d);
    chk(d == 8'h28, "R9 csel kept", d, 8'h28);
    chk(periph_wr_ok == en_vec(8'hA5, 8'h90), "R9 outputs", periph_wr_ok, en_vec(8'hA5, 8'h90));
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(periph_wr_ok == '0 && periph_rst == 11'h7FF, "R1 mid reset", {periph_wr_ok, periph_rst}, {11'h0, 11'h7FF});
    chk(can_clk_sel == '0 && can_clk_en == '0, "R1 mid csel", {can_clk_en, can_clk_sel}, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_walk_a();
    t_reg_b();
    t_csel();
    t_timing();
    t_gate_seq();
    t_unmapped();
    t_reset_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule